// File: doc/BRIEF.md
# Half-Duplex Line Driver Enable Controller

This block decides when a half-duplex, multi-drop line driver is allowed to drive the bus (`txen`) and when the line receiver listens (`rxen`). It takes mode fields from an extended modem control register, the DTR and RTS modem outputs, and the transmitter's status: data pending, shift register busy, and a one-per-bit-time tick. `txen` and `rxen` are registered, so a mode write never produces a glitch on either pin.

Four transmit-enable policies are offered. The driver can be enabled permanently, follow DTR, follow RTS, or toggle on its own. In the automatic policy, a three-state machine (IDLE, ACTIVE, HOLD) holds the driver on while data is queued or shifting. After the shift register empties it keeps the driver on for `HOLD_TICKS` more bit ticks, so the last stop bit is driven completely. The receiver can be enabled permanently or set to the inverse of the driver enable, which gives echo-free half-duplex operation.

The same block also routes auxiliary signals: `cts`, `rclk` and `auxout`. The routing is set by a loopback mode and two auxiliary-routing modes, and it is purely combinational.

Top module: `line_drv_enable_ctrl`

## Requirements
- R1: While `rst_n` is low, `txen` is 0 and `rxen` is 1.
- R2: With `txen_mode` = 2'b00, `txen` is 1 after the next rising edge.
- R3: With `txen_mode` = 2'b01, `txen` equals the value `dtr` had at the preceding rising edge.
- R4: With `txen_mode` = 2'b10, `txen` equals the value `rts` had at the preceding rising edge.
- R5: With `txen_mode` = 2'b11 (automatic), `txen` rises at the edge that samples `tx_pending` or `tx_busy` high.
- R6: In automatic mode, once `tx_pending` and `tx_busy` are both low, `txen` stays 1 until `HOLD_TICKS` sampled `bit_tick` pulses have been counted, and falls at the edge that samples the last one. New activity during the hold, including activity in the same cycle as the final tick, keeps `txen` at 1 and restarts the hold after the activity ends.
- R7: Leaving automatic mode during a hold discards the hold. Returning to automatic mode with no activity pending gives `txen` = 0 after the next edge.
- R8: With `rxen_mode` = 0, `rxen` is 1. With `rxen_mode` = 1, `rxen` is the inverse of `txen` in every cycle.
- R9: With `loop_mode` = 1: `rclk` = `tclk`, `auxout` = `auxin`, and `cts` = `rts`.
- R10: With `loop_mode` = 0, routing depends on the two auxiliary modes. `auxin_mode` = 0 gives `cts` = `auxin` and `rclk` = `tclk`. `auxin_mode` = 1 gives `rclk` = `auxin` and `cts` = `rts`. `auxout_mode` = 0 gives `auxout` = `rts`, and `auxout_mode` = 1 gives `auxout` = `tclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txen_mode | input | 2 | Transmit-enable policy: 00 on, 01 DTR, 10 RTS, 11 automatic |
| rxen_mode | input | 1 | 0: receiver always enabled; 1: inverse of driver enable |
| loop_mode | input | 1 | 1: loopback routing |
| auxin_mode | input | 1 | Routing choice for the auxiliary input |
| auxout_mode | input | 1 | Source choice for the auxiliary output |
| dtr | input | 1 | DTR modem output |
| rts | input | 1 | RTS modem output |
| tx_pending | input | 1 | Transmit data waiting |
| tx_busy | input | 1 | Transmit shift register not empty |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tclk | input | 1 | Transmit clock signal |
| auxin | input | 1 | Auxiliary input |
| txen | output | 1 | Line driver enable (registered) |
| rxen | output | 1 | Line receiver enable (registered) |
| auxout | output | 1 | Routed auxiliary output |
| cts | output | 1 | Routed clear-to-send |
| rclk | output | 1 | Routed receive clock signal |

## Verification
In automatic mode, the end of a hold and the start of a new transmission can fall in the same cycle. The bench provokes this by raising `tx_pending` in exactly the cycle that carries the final `bit_tick` of a hold. A correct design goes back to ACTIVE and keeps `txen` at 1, and a later, undisturbed hold must still count the full `HOLD_TICKS`. A mode change during a hold is a second collision, between a policy switch and the hold count. The bench judges it by returning to automatic mode with no activity pending and expecting `txen` low.

// File: rtl/lde_pkg.sv
package lde_pkg;
    typedef enum logic [1:0] {
        TXM_ON   = 2'b00,
        TXM_DTR  = 2'b01,
        TXM_RTS  = 2'b10,
        TXM_AUTO = 2'b11
    } txm_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_HOLD   = 2'b10
    } auto_st_e;
endpackage

// File: rtl/lde_auto_fsm.sv
module lde_auto_fsm #(
    parameter int HOLD_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_pending,
    input  logic tx_busy,
    input  logic bit_tick,
    output logic drive_req
);
    import lde_pkg::*;

    localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    auto_st_e       st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           activity;

    assign activity = tx_pending | tx_busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (activity) st_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!activity) begin
                        st_d  = ST_HOLD;
                        cnt_d = '0;
                    end
                end
                ST_HOLD: begin
                    if (activity) begin
                        st_d  = ST_ACTIVE;
                        cnt_d = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == LAST) begin
                            st_d  = ST_IDLE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        drive_req = (st_d != ST_IDLE);
    end
endmodule

// File: rtl/lde_enable_sel.sv
module lde_enable_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] txen_mode,
    input  logic       rxen_mode,
    input  logic       dtr,
    input  logic       rts,
    input  logic       auto_req,
    output logic       txen_q,
    output logic       rxen_q
);
    import lde_pkg::*;

    txm_e mode;
    logic tx_d;

    assign mode = txm_e'(txen_mode);

    always_comb begin
        unique case (mode)
            TXM_ON:   tx_d = 1'b1;
            TXM_DTR:  tx_d = dtr;
            TXM_RTS:  tx_d = rts;
            TXM_AUTO: tx_d = auto_req;
            default:  tx_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txen_q <= 1'b0;
            rxen_q <= 1'b1;
        end else begin
            txen_q <= tx_d;
            rxen_q <= rxen_mode ? ~tx_d : 1'b1;
        end
    end
endmodule

// File: rtl/lde_route.sv
module lde_route (
    input  logic loop_mode,
    input  logic auxin_mode,
    input  logic auxout_mode,
    input  logic rts,
    input  logic tclk,
    input  logic auxin,
    output logic auxout,
    output logic cts,
    output logic rclk
);
    always_comb begin
        if (loop_mode) begin
            rclk   = tclk;
            auxout = auxin;
            cts    = rts;
        end else begin
            rclk   = auxin_mode  ? auxin : tclk;
            cts    = auxin_mode  ? rts   : auxin;
            auxout = auxout_mode ? tclk  : rts;
        end
    end
endmodule

// File: rtl/line_drv_enable_ctrl.sv
module line_drv_enable_ctrl #(
    parameter int HOLD_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] txen_mode,
    input  logic       rxen_mode,
    input  logic       loop_mode,
    input  logic       auxin_mode,
    input  logic       auxout_mode,
    input  logic       dtr,
    input  logic       rts,
    input  logic       tx_pending,
    input  logic       tx_busy,
    input  logic       bit_tick,
    input  logic       tclk,
    input  logic       auxin,
    output logic       txen,
    output logic       rxen,
    output logic       auxout,
    output logic       cts,
    output logic       rclk
);
    logic auto_req;

    lde_auto_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (txen_mode == 2'b11),
        .tx_pending (tx_pending),
        .tx_busy    (tx_busy),
        .bit_tick   (bit_tick),
        .drive_req  (auto_req)
    );

    lde_enable_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .txen_mode (txen_mode),
        .rxen_mode (rxen_mode),
        .dtr       (dtr),
        .rts       (rts),
        .auto_req  (auto_req),
        .txen_q    (txen),
        .rxen_q    (rxen)
    );

    lde_route u_route (
        .loop_mode   (loop_mode),
        .auxin_mode  (auxin_mode),
        .auxout_mode (auxout_mode),
        .rts         (rts),
        .tclk        (tclk),
        .auxin       (auxin),
        .auxout      (auxout),
        .cts         (cts),
        .rclk        (rclk)
    );
endmodule

// File: rtl/lde_checker.sv
module lde_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] txen_mode,
    input logic       rxen_mode,
    input logic       loop_mode,
    input logic       dtr,
    input logic       rts,
    input logic       tx_pending,
    input logic       tx_busy,
    input logic       bit_tick,
    input logic       tclk,
    input logic       auxin,
    input logic       txen,
    input logic       rxen,
    input logic       auxout,
    input logic       cts,
    input logic       rclk
);
    a_r2_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_mode == 2'b00) |=> txen);

    a_r3_follow_dtr: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_mode == 2'b01) |=> (txen == $past(dtr)));

    a_r4_follow_rts: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_mode == 2'b10) |=> (txen == $past(rts)));

    a_r5_auto_start: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_mode == 2'b11 && (tx_pending || tx_busy)) |=> txen);

    a_r6_hold_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_mode == 2'b11 && $past(txen_mode) == 2'b11 && txen
         && !tx_pending && !tx_busy && !bit_tick) |=> txen);

    a_r8_rx_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        rxen_mode |=> (rxen == !txen));

    a_r8_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
        !rxen_mode |=> rxen);

    a_r9_loopback: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode |-> (rclk == tclk && auxout == auxin && cts == rts));
endmodule

bind line_drv_enable_ctrl lde_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txen_mode  (txen_mode),
    .rxen_mode  (rxen_mode),
    .loop_mode  (loop_mode),
    .dtr        (dtr),
    .rts        (rts),
    .tx_pending (tx_pending),
    .tx_busy    (tx_busy),
    .bit_tick   (bit_tick),
    .tclk       (tclk),
    .auxin      (auxin),
    .txen       (txen),
    .rxen       (rxen),
    .auxout     (auxout),
    .cts        (cts),
    .rclk       (rclk)
);

// File: tb/tb_line_drv_enable_ctrl.sv
module tb_line_drv_enable_ctrl;
    localparam int HT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] txen_mode = 2'b00;
    logic rxen_mode = 1'b0, loop_mode = 1'b0, auxin_mode = 1'b0, auxout_mode = 1'b0;
    logic dtr = 1'b0, rts = 1'b0, tx_pending = 1'b0, tx_busy = 1'b0, bit_tick = 1'b0;
    logic tclk = 1'b0, auxin = 1'b0;
    logic txen, rxen, auxout, cts, rclk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic  tx;
        logic  rx;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    line_drv_enable_ctrl #(.HOLD_TICKS(HT)) dut (
        .clk(clk), .rst_n(rst_n), .txen_mode(txen_mode), .rxen_mode(rxen_mode),
        .loop_mode(loop_mode), .auxin_mode(auxin_mode), .auxout_mode(auxout_mode),
        .dtr(dtr), .rts(rts), .tx_pending(tx_pending), .tx_busy(tx_busy),
        .bit_tick(bit_tick), .tclk(tclk), .auxin(auxin),
        .txen(txen), .rxen(rxen), .auxout(auxout), .cts(cts), .rclk(rclk)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // driver: inputs already set at negedge; push expectation for after next edge
    task automatic step(input logic etx, input logic erx, input string tag);
        exp_t e;
        e.tx = etx; e.rx = erx; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pop after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(txen, e.tx, {e.tag, " txen"});
                chk(rxen, e.rx, {e.tag, " rxen"});
            end
        end
    end

    task automatic route(input logic lm, input logic im, input logic om,
                         input logic r, input logic t, input logic a,
                         input logic ects, input logic erclk, input logic eaux,
                         input string tag);
        loop_mode = lm; auxin_mode = im; auxout_mode = om;
        rts = r; tclk = t; auxin = a;
        #1;
        chk(cts, ects, {tag, " cts"});
        chk(rclk, erclk, {tag, " rclk"});
        chk(auxout, eaux, {tag, " auxout"});
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(txen, 1'b0, "R1 reset");
        chk(rxen, 1'b1, "R1 reset");
        rst_n = 1'b1;
        // R2
        txen_mode = 2'b00; step(1, 1, "R2 on");
        // R3
        txen_mode = 2'b01; dtr = 0; step(0, 1, "R3 dtr0");
        dtr = 1; step(1, 1, "R3 dtr1");
        dtr = 0; step(0, 1, "R3 dtr0b");
        // R4 with R8 inverse
        rxen_mode = 1; txen_mode = 2'b10; rts = 1; step(1, 0, "R4 R8 rts1");
        rts = 0; step(0, 1, "R4 R8 rts0");
        rxen_mode = 0; rts = 1; step(1, 1, "R8 rx on");
        rts = 0;
        // R5 / R6 automatic
        txen_mode = 2'b11; step(0, 1, "R5 idle");
        tx_pending = 1; step(1, 1, "R5 start");
        tx_pending = 0; tx_busy = 1; step(1, 1, "R6 busy");
        tx_busy = 0; step(1, 1, "R6 hold0");
        bit_tick = 1; step(1, 1, "R6 tick1");
        bit_tick = 0; step(1, 1, "R6 gap");
        bit_tick = 1; step(0, 1, "R6 expire");
        bit_tick = 0; step(0, 1, "R6 idle");
        // activity during hold restarts count
        tx_pending = 1; step(1, 1, "R6 re1");
        tx_pending = 0; step(1, 1, "R6 re hold");
        bit_tick = 1; step(1, 1, "R6 re tick");
        bit_tick = 0; tx_pending = 1; step(1, 1, "R6 re active");
        tx_pending = 0; step(1, 1, "R6 re hold2");
        bit_tick = 1; step(1, 1, "R6 restart tick1");
        step(0, 1, "R6 restart expire");
        bit_tick = 0;
        // collision: final tick with new pending
        tx_pending = 1; step(1, 1, "R6 col a");
        tx_pending = 0; step(1, 1, "R6 col hold");
        bit_tick = 1; step(1, 1, "R6 col tick1");
        tx_pending = 1; step(1, 1, "R6 col same cycle");
        tx_pending = 0; bit_tick = 0; step(1, 1, "R6 col hold again");
        bit_tick = 1; step(1, 1, "R6 col t1");
        step(0, 1, "R6 col expire");
        bit_tick = 0;
        // R7 leave auto mid-hold
        tx_pending = 1; step(1, 1, "R7 a");
        tx_pending = 0; step(1, 1, "R7 hold");
        bit_tick = 1; step(1, 1, "R7 tick1");
        bit_tick = 0; txen_mode = 2'b00; step(1, 1, "R7 leave");
        txen_mode = 2'b11; step(0, 1, "R7 return idle");
        // R8 inverse in auto
        rxen_mode = 1; tx_busy = 1; step(1, 0, "R8 auto inv");
        tx_busy = 0; rxen_mode = 0;
        repeat (2) @(negedge clk);
        // R9 / R10 routing
        route(1, 0, 0, 1, 0, 1, 1, 0, 1, "R9 loop a");
        route(1, 1, 1, 0, 1, 0, 0, 1, 0, "R9 loop b");
        route(0, 0, 0, 0, 1, 1, 1, 1, 0, "R10 in0 out0");
        route(0, 1, 1, 0, 1, 1, 0, 1, 1, "R10 in1 out1");
        route(0, 1, 0, 1, 0, 0, 1, 0, 1, "R10 in1 out0");
        route(0, 0, 1, 1, 0, 1, 1, 0, 0, "R10 in0 out1");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) chk(1'b1, 1'b0, "scoreboard drained");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule